// File: doc/BRIEF.md
# Configurable Look-Up-Table Logic Cell

This block is one programmable cell meant to be tiled across a reconfigurable fabric. A 16-entry one-bit table, addressed by four logic inputs, can produce any Boolean function of those inputs. The table contents and two option bits are loaded as a serial stream. Each clock with `cfg_en` high shifts one bit in. No other path writes the configuration.

One option bit picks the cell output. The output is either the table value read directly or that value captured in a flip-flop on the previous clock. The other option bit turns the table into a 16x1 RAM. In that mode a write port stores data at the location the logic inputs address, and reads stay combinational. Reset clears only the output flip-flop. The configuration survives reset.

Top module: `lut_logic_cell`

## Requirements
- R1: The configuration chain is 18 bits long. With `cfg_en` high it takes in one bit from `cfg_in` on each rising clock edge. After 18 shifts, the first bit sent sits in table location 0 and bits 2 to 16 sit in locations 1 to 15. Bit 17 is the output-register enable and bit 18, the last one sent, is the RAM-mode enable.
- R2: Table location k holds the function value for the input combination k, where `sel[3]` is the most significant bit of k. With the register enable at 0, `cell_out` equals location `sel` in the same cycle.
- R3: With the output-register enable at 0, `cell_out` follows changes on `sel` without waiting for a clock edge.
- R4: With the output-register enable at 1 and `cfg_en` low, `cell_out` shows the table value that was selected at the previous rising clock edge.
- R5: Asserting `rst_n` low clears the output flip-flop to 0 at once. Reset does not change the configuration chain.
- R6: While `cfg_en` is high, the output flip-flop holds its value and the write port is ignored.
- R7: With the RAM-mode bit at 1, `cfg_en` low and `we` high, `din` is stored at location `sel` on the rising edge. The stored value is visible combinationally from then on.
- R8: With the RAM-mode bit at 0, `we` has no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain, the RAM write and the output flip-flop |
| rst_n | input | 1 | Asynchronous active-low reset of the output flip-flop |
| cfg_en | input | 1 | Shift-enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration data |
| sel | input | 4 | Logic inputs, also the RAM address |
| we | input | 1 | RAM write enable |
| din | input | 1 | RAM write data |
| cell_out | output | 1 | Cell output |

## Verification
Assertions check three things on every clock:
- the chain shifts by one position per enabled clock, with the newest bit at the RAM-mode end;
- a RAM write lands at the addressed location, and the chain stays frozen when neither a shift nor a write is active;
- the output flip-flop holds during configuration and otherwise captures the table value.

Only the bench scenarios can show the rest. These are the mapping from input combination to table location under AND, OR, XOR and random tables, the choice between combinational and registered output, and that reset leaves the table intact. They also cover readback at every RAM address and writes that are dropped in LUT mode or during shifting.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  // Number of configuration bits for a table with w select inputs.
  function automatic int chain_len(input int w);
    return (1 << w) + 2;
  endfunction

  // Position of the output-register enable in the chain.
  function automatic int reg_pos(input int w);
    return (1 << w);
  endfunction

  // Position of the RAM-mode enable, the last bit shifted in.
  function automatic int ram_pos(input int w);
    return (1 << w) + 1;
  endfunction

  typedef enum logic {OUT_DIRECT = 1'b0, OUT_FLOPPED = 1'b1} out_sel_e;
endpackage

// File: rtl/cfg_store.sv
module cfg_store
  import lut_cell_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en,
  input  logic                  cfg_in,
  input  logic                  we,
  input  logic                  din,
  input  logic [SEL_W-1:0]      addr,
  output logic [(1<<SEL_W)-1:0] tbl,
  output logic                  reg_en,
  output logic                  ram_mode
);
  localparam int DEPTH = 1 << SEL_W;
  localparam int CLEN  = chain_len(SEL_W);
  localparam int RPOS  = reg_pos(SEL_W);
  localparam int MPOS  = ram_pos(SEL_W);

  logic [CLEN-1:0] chain;
  logic            wr_fire;   // RAM write accepted this cycle
  logic            shift_ev;  // configuration shift this cycle

  assign shift_ev = cfg_en;
  assign wr_fire  = !cfg_en && we && ram_mode;

  always_ff @(posedge clk) begin
    if (shift_ev) begin
      chain <= {cfg_in, chain[CLEN-1:1]};
    end else if (wr_fire) begin
      chain[addr] <= din;
    end
  end

  assign tbl      = chain[DEPTH-1:0];
  assign reg_en   = chain[RPOS];
  assign ram_mode = chain[MPOS];

  // R1: newest bit appears at the RAM-mode end, older bit moves one step
  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> ram_mode == $past(cfg_in));
  a_r1_shift_along: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> reg_en == $past(ram_mode));
  // R7: accepted write lands at the addressed location
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> tbl[$past(addr)] == $past(din));
  // R6/R8: no shift and no accepted write leaves the chain frozen
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_ev && !wr_fire) |=> $stable(chain));
endmodule

// File: rtl/lut_read.sv
module lut_read #(
  parameter int SEL_W = 4
) (
  input  logic [(1<<SEL_W)-1:0] tbl,
  input  logic [SEL_W-1:0]      sel,
  output logic                  y
);
  localparam int DEPTH = 1 << SEL_W;

  function automatic logic pick(input logic [DEPTH-1:0] t, input logic [SEL_W-1:0] s);
    return t[s];
  endfunction

  assign y = pick(tbl, sel);
endmodule

// File: rtl/out_stage.sv
module out_stage
  import lut_cell_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic d,
  input  logic reg_en,
  output logic y
);
  logic     q_r;
  out_sel_e mode;

  assign mode = out_sel_e'(reg_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= 1'b0;
    else if (!hold) q_r <= d;
  end

  assign y = (mode == OUT_FLOPPED) ? q_r : d;

  // R6: flip-flop frozen while configuring
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(q_r));
  // R4: flip-flop captures the table value otherwise
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> q_r == $past(d));
endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             we,
  input  logic             din,
  output logic             cell_out
);
  localparam int DEPTH = 1 << SEL_W;

  logic [DEPTH-1:0] tbl;
  logic             reg_en;
  logic             ram_mode;
  logic             lut_val;

  cfg_store #(.SEL_W(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .we(we), .din(din), .addr(sel),
    .tbl(tbl), .reg_en(reg_en), .ram_mode(ram_mode)
  );

  lut_read #(.SEL_W(SEL_W)) u_read (
    .tbl(tbl), .sel(sel), .y(lut_val)
  );

  out_stage u_out (
    .clk(clk), .rst_n(rst_n), .hold(cfg_en), .d(lut_val),
    .reg_en(reg_en), .y(cell_out)
  );
endmodule

// File: tb/lut_logic_cell_tb.sv
module lut_logic_cell_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_in = 1'b0;
  logic [3:0] sel = 4'd0;
  logic       we = 1'b0;
  logic       din = 1'b0;
  logic       cell_out;

  int  total = 0;
  int  bad = 0;
  bit  checking = 1'b0;
  bit  done = 1'b0;

  // behavioural reference: truth bits, two option bits, output flop
  bit  m_tab [16];
  bit  m_regen, m_ram, m_q;

  lut_logic_cell u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .sel(sel), .we(we), .din(din), .cell_out(cell_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_q <= 1'b0;
    else if (!cfg_en) m_q <= m_tab[sel];
  end

  always @(posedge clk) begin
    if (cfg_en) begin
      // the first bit sent ends up in table entry 0
      for (int i = 0; i < 15; i++) m_tab[i] <= m_tab[i+1];
      m_tab[15] <= m_regen;
      m_regen   <= m_ram;
      m_ram     <= cfg_in;
    end else if (m_ram && we) begin
      m_tab[sel] <= din;
    end
  end

  function automatic bit expected();
    return m_regen ? m_q : m_tab[sel];
  endfunction

  task automatic compare(input string tag);
    bit e;
    e = expected();
    total++;
    if (cell_out !== e) begin
      bad++;
      $display("FAIL %s sel=%0d actual=%b expected=%b", tag, sel, cell_out, e);
    end
  endtask

  // inputs applied after negedge, compared a quarter period later, then one clock
  task automatic step(input string tag, input bit ce, input bit ci,
                      input logic [3:0] s, input bit w, input bit d);
    cfg_en = ce; cfg_in = ci; sel = s; we = w; din = d;
    #(CLK_PERIOD/4);
    if (checking) compare(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] t, input bit r, input bit m, input bit wjunk);
    for (int i = 0; i < 16; i++) step("R1", 1'b1, t[i], 4'(i), wjunk, ~t[i]);
    step("R1", 1'b1, r, 4'd0, wjunk, 1'b1);
    step("R1", 1'b1, m, 4'd0, wjunk, 1'b1);
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 16; k++) step(tag, 1'b0, 1'b0, 4'(k), 1'b0, 1'b0);
  endtask

  task automatic both_modes(input logic [15:0] t);
    load(t, 1'b0, 1'b0, 1'b0);
    sweep("R2");
    load(t, 1'b1, 1'b0, 1'b0);
    sweep("R4");
    step("R4", 1'b0, 1'b0, 4'd0, 1'b0, 1'b0);
  endtask

  initial begin
    logic [15:0] rnd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    load(16'h8000, 1'b0, 1'b0, 1'b0);
    checking = 1'b1;
    sweep("R2");                    // AND
    load(16'h8000, 1'b1, 1'b0, 1'b0);
    sweep("R4");
    both_modes(16'hFFFE);           // OR
    both_modes(16'h6996);           // XOR
    rnd = 16'($urandom(32'd7));
    both_modes(rnd);

    // R3: combinational output follows sel without a clock edge
    load(16'h6996, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 16; k++) begin
      sel = 4'(k);
      #1;
      compare("R3");
    end
    @(negedge clk);

    // R8: writes in LUT mode are dropped
    for (int k = 0; k < 16; k++) step("R8", 1'b0, 1'b0, 4'(k), 1'b1, 1'b1);
    sweep("R8");

    // R5: reset clears flop, keeps configuration
    load(16'hFFFE, 1'b1, 1'b0, 1'b0);
    step("R5", 1'b0, 1'b0, 4'd5, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    compare("R5");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R5");

    // R6: writes during shifting ignored, flop held while loading RAM mode
    load(16'h0000, 1'b0, 1'b1, 1'b1);
    sweep("R6");

    // R7: RAM write and readback at every address, two patterns
    for (int k = 0; k < 16; k++) step("R7", 1'b0, 1'b0, 4'(k), 1'b1, k[0] ^ k[2]);
    sweep("R7");
    for (int k = 0; k < 16; k++) step("R7", 1'b0, 1'b0, 4'(k), 1'b1, ~(k[0] ^ k[2]));
    sweep("R7");
    load(16'h0F0F, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++) step("R7", 1'b0, 1'b0, 4'(k), 1'b1, k[1]);
    sweep("R7");

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule